// File: doc/BRIEF.md
# Reset One-Shot Delay Timer

This block produces the internal reset hold-off that keeps a processor stopped while its supply and main oscillator settle. It runs on its own free-running RC-oscillator clock, not on the system clock. It acts as a retriggerable one-shot. When it fires, it holds the internal reset high for a fixed number of RC ticks and then releases it.

Three events fire the one-shot:
- the power-good level rising after a fail period;
- a watchdog time-out pulse;
- a stop-mode wake-up event, but only when the wake-delay register bit is set.

When that bit is clear, a wake-up skips the delay entirely. This setting suits systems with an external clock or an RC/LC oscillator, which need no settling time. The delay length is the parameter `DELAY_TICKS`, counted in RC ticks. A nominal 5 ms at a 32 kHz RC clock is roughly 160 ticks.

Top module: `reset_oneshot`

## Requirements
- R1: While `rst` is high at a clock edge, `hold_rst` is 1 and `settle_done` is 0 after that edge. The power status is then treated as "fail", so power-good being high at the first edge after `rst` falls starts a delay.
- R2: While `pwr_ok` is low at a clock edge, `hold_rst` is 1 and `settle_done` is 0 after that edge. Trigger inputs are ignored during that time. A later rise of `pwr_ok` starts a full delay counted from zero.
- R3: A delay is started by the clock edge that samples `pwr_ok` high after a fail period. Starting from that edge, `hold_rst` stays 1 for exactly `DELAY_TICKS` clock cycles and falls at the `DELAY_TICKS`-th following edge.
- R4: A `wdog_expire` pulse sampled with `pwr_ok` high starts a delay of exactly `DELAY_TICKS` cycles. It does so whether the timer is counting or released.
- R5: A `stop_wake` pulse sampled with `wake_delay_en` = 1 and `pwr_ok` high starts a delay of exactly `DELAY_TICKS` cycles.
- R6: A `stop_wake` pulse with `wake_delay_en` = 0 has no effect. When released, `hold_rst` stays 0. During a count, the release edge does not move.
- R7: A qualifying trigger during an active count restarts the count from zero. Reset is then released `DELAY_TICKS` cycles after the restarting edge.
- R8: `settle_done` is always the inverse of `hold_rst`.
- R9: `wdog_expire` together with a bypassed `stop_wake` (`wake_delay_en` = 0) still starts a delay, because the watchdog takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running RC-oscillator tick clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply-good level, 1 = supply OK |
| stop_wake | input | 1 | One-cycle stop-mode wake-up event |
| wdog_expire | input | 1 | One-cycle watchdog time-out pulse |
| wake_delay_en | input | 1 | 1 = wake-up runs the delay, 0 = wake-up bypasses it |
| hold_rst | output | 1 | Internal reset to the processor, active high |
| settle_done | output | 1 | 1 once the delay has expired and reset is released |

## Verification
The bench measures the exact length of the reset pulse from each of the three sources. A design off by one in its terminal-count compare would show a pulse of `DELAY_TICKS`±1.

It fires triggers in the middle of a count. A design that ignored a retrigger, or that resumed the count instead of clearing it, would release early.

It sends bypassed wake-ups, both while released and while counting. A design that treated the bypass bit wrongly would either assert reset or stretch the count.

Power loss during a count and triggers during power fail check that power-good dominates. The check also confirms that the rise after a fail period restarts from zero rather than continuing an old count.

// File: rtl/reset_oneshot_pkg.sv
package reset_oneshot_pkg;

    typedef enum logic [1:0] {
        PH_FAIL  = 2'd0,
        PH_COUNT = 2'd1,
        PH_RUN   = 2'd2
    } phase_t;

    typedef struct packed {
        logic wdog;
        logic wake_slow;
    } trig_t;

    function automatic trig_t decode_trig(input logic wdog_in,
                                          input logic wake_in,
                                          input logic delay_en);
        trig_t t;
        t.wdog      = wdog_in;
        t.wake_slow = wake_in & delay_en;
        return t;
    endfunction

    function automatic logic any_restart(input trig_t t);
        return t.wdog | t.wake_slow;
    endfunction

endpackage

// File: rtl/reset_oneshot_trig.sv
module reset_oneshot_trig
    import reset_oneshot_pkg::*;
(
    input  logic wdog_expire,
    input  logic stop_wake,
    input  logic wake_delay_en,
    output logic restart
);
    trig_t trig;

    always_comb begin
        trig    = decode_trig(wdog_expire, stop_wake, wake_delay_en);
        restart = any_restart(trig);
    end
endmodule

// File: rtl/reset_oneshot_cnt.sv
module reset_oneshot_cnt #(
    parameter int DELAY_TICKS = 160
) (
    input  logic clk,
    input  logic clear,
    input  logic inc,
    output logic at_end
);
    localparam int CW = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clear)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign at_end = (cnt == LAST);
endmodule

// File: rtl/reset_oneshot_seq.sv
module reset_oneshot_seq
    import reset_oneshot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic restart,
    input  logic at_end,
    output logic clear,
    output logic inc,
    output logic hold_rst,
    output logic settle_done
);
    phase_t phase, phase_nxt;

    always_comb begin
        phase_nxt = phase;
        clear     = 1'b0;
        inc       = 1'b0;
        if (rst || !pwr_ok) begin
            phase_nxt = PH_FAIL;
            clear     = 1'b1;
        end else begin
            case (phase)
                PH_FAIL: begin
                    phase_nxt = PH_COUNT;
                    clear     = 1'b1;
                end
                PH_COUNT: begin
                    if (restart)
                        clear = 1'b1;
                    else if (at_end)
                        phase_nxt = PH_RUN;
                    else
                        inc = 1'b1;
                end
                PH_RUN: begin
                    if (restart) begin
                        phase_nxt = PH_COUNT;
                        clear     = 1'b1;
                    end
                end
                default: begin
                    phase_nxt = PH_FAIL;
                    clear     = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        phase <= phase_nxt;
    end

    assign hold_rst    = (phase != PH_RUN);
    assign settle_done = (phase == PH_RUN);
endmodule

// File: rtl/reset_oneshot.sv
module reset_oneshot #(
    parameter int DELAY_TICKS = 160
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic stop_wake,
    input  logic wdog_expire,
    input  logic wake_delay_en,
    output logic hold_rst,
    output logic settle_done
);
    logic restart;
    logic clear;
    logic inc;
    logic at_end;

    reset_oneshot_trig u_trig (
        .wdog_expire  (wdog_expire),
        .stop_wake    (stop_wake),
        .wake_delay_en(wake_delay_en),
        .restart      (restart)
    );

    reset_oneshot_cnt #(.DELAY_TICKS(DELAY_TICKS)) u_cnt (
        .clk   (clk),
        .clear (clear),
        .inc   (inc),
        .at_end(at_end)
    );

    reset_oneshot_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .pwr_ok     (pwr_ok),
        .restart    (restart),
        .at_end     (at_end),
        .clear      (clear),
        .inc        (inc),
        .hold_rst   (hold_rst),
        .settle_done(settle_done)
    );
endmodule

// File: rtl/reset_oneshot_chk.sv
module reset_oneshot_chk #(
    parameter int DELAY_TICKS = 160
) (
    input logic clk,
    input logic rst,
    input logic pwr_ok,
    input logic stop_wake,
    input logic wdog_expire,
    input logic wake_delay_en,
    input logic hold_rst,
    input logic settle_done
);
    localparam int AW = $clog2(DELAY_TICKS + 2);
    localparam logic [AW-1:0] TOP = AW'(DELAY_TICKS + 1);
    localparam logic [AW-1:0] LEN = AW'(DELAY_TICKS);

    logic [AW-1:0] age;

    always_ff @(posedge clk) begin
        if (rst || !pwr_ok || wdog_expire || (stop_wake && wake_delay_en))
            age <= '0;
        else if (hold_rst && age != TOP)
            age <= age + 1'b1;
    end

    assert_rst_holds_R1: assert property (@(posedge clk)
        rst |=> (hold_rst && !settle_done));

    assert_pwr_fail_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> (hold_rst && !settle_done));

    assert_hold_not_too_long_R3: assert property (@(posedge clk) disable iff (rst)
        hold_rst |-> (age <= LEN));

    assert_release_not_early_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_rst) |-> (age >= LEN));

    assert_wdog_fires_R4: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && wdog_expire) |=> hold_rst);

    assert_wake_fires_R5: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && stop_wake && wake_delay_en) |=> hold_rst);

    assert_bypass_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && settle_done && stop_wake && !wake_delay_en && !wdog_expire)
        |=> settle_done);

    assert_done_inverse_R8: assert property (@(posedge clk) disable iff (rst)
        settle_done != hold_rst);
endmodule

bind reset_oneshot reset_oneshot_chk #(.DELAY_TICKS(DELAY_TICKS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pwr_ok       (pwr_ok),
    .stop_wake    (stop_wake),
    .wdog_expire  (wdog_expire),
    .wake_delay_en(wake_delay_en),
    .hold_rst     (hold_rst),
    .settle_done  (settle_done)
);

// File: tb/reset_oneshot_test.sv
`timescale 1ns/1ps
module reset_oneshot_test;
    localparam int D = 6;

    logic clk = 1'b0;
    logic rst, pwr_ok, stop_wake, wdog_expire, wake_delay_en;
    logic hold_rst, settle_done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    reset_oneshot #(.DELAY_TICKS(D)) uut (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .stop_wake(stop_wake),
        .wdog_expire(wdog_expire), .wake_delay_en(wake_delay_en),
        .hold_rst(hold_rst), .settle_done(settle_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // count negedge samples with hold_rst high, starting from the one just after the current point
    task automatic count_hold(output int n);
        n = 0;
        for (int i = 0; i < 4 * D + 8; i++) begin
            @(negedge clk);
            if (!hold_rst) break;
            n++;
        end
    endtask

    task automatic power_up_released();
        pwr_ok = 1'b0;
        @(negedge clk);
        pwr_ok = 1'b1;
        for (int i = 0; i < D + 2; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        int n;
        rst = 1'b1; pwr_ok = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 hold in reset", hold_rst, 1);
        check("R8 done in reset", settle_done, 0);
        rst = 1'b0;
        count_hold(n);
        check("R1 delay after reset release", n, D);
        check("R8 done after release", settle_done, 1);
    endtask

    task automatic t_power_up();
        int n;
        pwr_ok = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 hold while power fail", hold_rst, 1);
        pwr_ok = 1'b1;
        count_hold(n);
        check("R3 power-up delay length", n, D);
    endtask

    task automatic t_wdog_run();
        int n;
        power_up_released();
        wdog_expire = 1'b1;
        @(negedge clk);
        wdog_expire = 1'b0;
        n = hold_rst ? 1 : 0;
        if (hold_rst) begin
            int m;
            count_hold(m);
            n += m;
        end
        check("R4 watchdog delay length", n, D);
    endtask

    task automatic t_wake(input logic en, input string req, input int exp);
        int n;
        power_up_released();
        wake_delay_en = en;
        stop_wake = 1'b1;
        @(negedge clk);
        stop_wake = 1'b0;
        n = hold_rst ? 1 : 0;
        if (hold_rst) begin
            int m;
            count_hold(m);
            n += m;
        end
        check(req, n, exp);
        wake_delay_en = 1'b1;
    endtask

    task automatic t_restart_mid();
        int n, m;
        pwr_ok = 1'b0;
        @(negedge clk);
        pwr_ok = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 counting before retrigger", hold_rst, 1);
        wdog_expire = 1'b1;
        @(negedge clk);
        wdog_expire = 1'b0;
        count_hold(m);
        n = 1 + m;
        check("R7 retrigger restarts from zero", n, D);
    endtask

    task automatic t_bypass_mid();
        int n, m;
        pwr_ok = 1'b0;
        @(negedge clk);
        pwr_ok = 1'b1;
        @(negedge clk);
        n = 1;
        wake_delay_en = 1'b0;
        stop_wake = 1'b1;
        @(negedge clk);
        stop_wake = 1'b0;
        n++;
        count_hold(m);
        n += m;
        check("R6 bypassed wake during count", n, D);
        wake_delay_en = 1'b1;
    endtask

    task automatic t_power_drop();
        int n;
        power_up_released();
        pwr_ok = 1'b0;
        @(negedge clk);
        check("R2 power drop asserts hold", hold_rst, 1);
        check("R8 power drop clears done", settle_done, 0);
        wdog_expire = 1'b1;
        stop_wake = 1'b1;
        repeat (D + 3) @(negedge clk);
        wdog_expire = 1'b0;
        stop_wake = 1'b0;
        check("R2 triggers ignored in power fail", hold_rst, 1);
        pwr_ok = 1'b1;
        count_hold(n);
        check("R2 full delay after power return", n, D);
    endtask

    task automatic t_priority();
        int n, m;
        power_up_released();
        wake_delay_en = 1'b0;
        stop_wake = 1'b1;
        wdog_expire = 1'b1;
        @(negedge clk);
        stop_wake = 1'b0;
        wdog_expire = 1'b0;
        check("R9 watchdog beats bypass", hold_rst, 1);
        count_hold(m);
        n = 1 + m;
        check("R9 delay length with both", n, D);
        wake_delay_en = 1'b1;
    endtask

    initial begin
        rst = 1'b1; pwr_ok = 1'b0; stop_wake = 1'b0;
        wdog_expire = 1'b0; wake_delay_en = 1'b1;
        @(negedge clk);
        t_reset();
        t_power_up();
        t_wdog_run();
        t_wake(1'b1, "R5 delayed wake length", D);
        t_wake(1'b0, "R6 bypassed wake while released", 0);
        t_restart_mid();
        t_bypass_mid();
        t_power_drop();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule